// File: doc/BRIEF.md
# Cascaded backplane sync controller

This block steps one display driver through its backplane phases and keeps that driver in step with the other drivers of a cascade that share one wired-AND sync line. A common frame-step enable moves the phase counter forward by one phase. The multiplex mode sets how many phases make up a frame. When the driver enters the last phase of a frame, it pulls the shared line low for a short, fixed pulse. At all other times it only watches the line.

The line is read through a synchronizer chain. A falling edge that the driver did not cause itself means that another driver in the cascade has just entered its last phase. The driver records this and, on the next frame step, loads its own counter with the last-phase index. From then on it follows the driver that pulled the line first. Nothing else is needed to repair a cascade that has drifted apart, for example after a change of mode.

Top module: `bp_sync_ctrl`

## Requirements
- R1: During and after synchronous reset, `bp_index` is 0 and `sync_pull_down` is 0.
- R2: `mux_mode` selects the frame length: 2'b00 gives 1 phase, 2'b01 gives 2 phases, 2'b10 gives 3 phases and 2'b11 gives 4 phases. On each cycle with `frame_step` high and no realignment due, `bp_index` goes up by one, and it goes from the last index (the mode value) back to 0. In the 1-phase mode it stays 0.
- R3: On a cycle with `frame_step` low, `bp_index` keeps its value.
- R4: A frame step that moves the counter into the last phase by normal advance drives `sync_pull_down` high from the next cycle for exactly PULSE_LEN cycles.
- R5: `sync_line_in` is the line level, and low means asserted. A falling edge of the line that this driver did not cause makes the next frame step load `bp_index` with the last index. That step starts no pull-down pulse.
- R6: A falling edge of the line that comes from this driver's own pull-down does not realign the counter.
- R7: A line level that is first sampled low at clock edge j is acted on by a frame step at edge j+SYNC_STAGES or later. A frame step at an earlier edge advances normally.
- R8: If `bp_index` is at or above the last index of a newly selected mode, the next normal frame step sets it to 0.
- R9: A detected foreign edge realigns only one frame step. The steps after it advance normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_step | input | 1 | One-cycle enable that advances the backplane phase |
| mux_mode | input | 2 | Multiplex mode; the value is the last phase index |
| sync_line_in | input | 1 | Sampled level of the shared open-drain sync line |
| bp_index | output | 2 | Current backplane phase |
| sync_pull_down | output | 1 | High to pull the shared sync line low |

## Verification
The bench runs all four modes free, with only the driver's own pulses on the line. This separates correct wrap-around and pulse placement from false realignment on self-generated edges. It then injects a foreign pulse during a mid-frame phase to check the load to the last index, the missing pulse and the return to normal stepping. It places a foreign pulse one edge too late for the following step to see it, which pins the synchronizer latency. It also shrinks the mode while the counter is above the new limit. A behavioural reference model built on history queues is compared with both outputs on every cycle.

// File: rtl/bpsync_pkg.sv
package bpsync_pkg;

    typedef enum logic [1:0] {
        MUX_STATIC = 2'd0,
        MUX_2      = 2'd1,
        MUX_3      = 2'd2,
        MUX_4      = 2'd3
    } mux_mode_e;

    localparam int PHASE_W = 2;

    typedef logic [PHASE_W-1:0] phase_t;

    typedef struct packed {
        logic   step;
        logic   realign;
        phase_t last;
    } seq_ctl_t;

    function automatic phase_t last_phase(mux_mode_e m);
        return phase_t'(m);
    endfunction

endpackage

// File: rtl/bpsync_edge.sv
module bpsync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    input  logic own_i,
    output logic fall_o
);
    logic [STAGES-1:0] lvl_q;
    logic [STAGES-1:0] own_q;
    logic              prev_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    lvl_q[g] <= 1'b1;
                    own_q[g] <= 1'b0;
                end else begin
                    lvl_q[g] <= line_i;
                    own_q[g] <= own_i;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) begin
                    lvl_q[g] <= 1'b1;
                    own_q[g] <= 1'b0;
                end else begin
                    lvl_q[g] <= lvl_q[g-1];
                    own_q[g] <= own_q[g-1];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= lvl_q[STAGES-1];
    end

    // falling edge at the end of the chain, unless it was caused by our own pull-down
    assign fall_o = prev_q & ~lvl_q[STAGES-1] & ~own_q[STAGES-1];

endmodule

// File: rtl/bpsync_phase_seq.sv
module bpsync_phase_seq
    import bpsync_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      step_i,
    input  mux_mode_e mode_i,
    input  logic      fall_i,
    output phase_t    phase_o,
    output logic      start_o
);
    phase_t   ph_q, ph_d;
    logic     pend_q;
    seq_ctl_t ctl;

    always_comb begin
        ctl.step    = step_i;
        ctl.realign = pend_q | fall_i;
        ctl.last    = last_phase(mode_i);
        ph_d        = ph_q;
        start_o     = 1'b0;
        if (ctl.step) begin
            if (ctl.realign) begin
                ph_d = ctl.last;
            end else begin
                ph_d    = (ph_q >= ctl.last) ? '0 : ph_q + 1'b1;
                start_o = (ph_d == ctl.last);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= '0;
            pend_q <= 1'b0;
        end else begin
            ph_q <= ph_d;
            if (step_i)      pend_q <= 1'b0;
            else if (fall_i) pend_q <= 1'b1;
        end
    end

    assign phase_o = ph_q;

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> $stable(ph_q));

    p_realign_r5: assert property (@(posedge clk) disable iff (rst)
        (step_i && (pend_q || fall_i)) |=> (ph_q == $past(last_phase(mode_i))));

    p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (step_i && !pend_q && !fall_i && ph_q >= last_phase(mode_i)) |=> (ph_q == '0));

endmodule

// File: rtl/bpsync_pulse.sv
module bpsync_pulse #(
    parameter int PULSE_LEN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic drive_o
);
    localparam int CNT_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;

    logic             drv_q;
    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q  <= 1'b0;
            left_q <= '0;
        end else if (start_i) begin
            drv_q  <= 1'b1;
            left_q <= CNT_W'(PULSE_LEN - 1);
        end else if (drv_q) begin
            if (left_q == '0) drv_q  <= 1'b0;
            else              left_q <= left_q - 1'b1;
        end
    end

    assign drive_o = drv_q;

    p_start_r4: assert property (@(posedge clk) disable iff (rst)
        start_i |=> drive_o);

    p_rise_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_o) |-> $past(start_i));

endmodule

// File: rtl/bp_sync_ctrl.sv
module bp_sync_ctrl
    import bpsync_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PULSE_LEN   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_step,
    input  logic [1:0] mux_mode,
    input  logic       sync_line_in,
    output logic [1:0] bp_index,
    output logic       sync_pull_down
);
    mux_mode_e mode;
    logic      fall;
    logic      start;
    phase_t    phase;

    assign mode = mux_mode_e'(mux_mode);

    bpsync_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .line_i (sync_line_in),
        .own_i  (sync_pull_down),
        .fall_o (fall)
    );

    bpsync_phase_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .step_i  (frame_step),
        .mode_i  (mode),
        .fall_i  (fall),
        .phase_o (phase),
        .start_o (start)
    );

    bpsync_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .drive_o (sync_pull_down)
    );

    assign bp_index = phase;

    p_static_r2: assert property (@(posedge clk) disable iff (rst)
        (frame_step && mux_mode == 2'b00) |=> (bp_index == 2'd0));

    p_range_r2: assert property (@(posedge clk) disable iff (rst)
        frame_step |=> (bp_index <= $past(mux_mode)));

endmodule

// File: tb/bp_sync_ctrl_tb_top.sv
module bp_sync_ctrl_tb_top;
    localparam int N  = 2;
    localparam int PL = 2;

    logic       clk = 1'b0;
    logic       rst;
    logic       step;
    logic [1:0] mode;
    logic       foreign;
    logic       line;
    logic [1:0] bp_index;
    logic       pull;

    int    checks = 0;
    int    errors = 0;
    bit    cmp_en = 0;
    string cur_req = "R1";

    // reference model state
    int m_ph   = 0;
    bit m_pend = 0;
    bit m_drv  = 0;
    int m_left = 0;
    bit line_h[$];
    bit drv_h[$];

    always #2.5 clk = ~clk;

    assign line = ~(pull | foreign);

    bp_sync_ctrl #(.SYNC_STAGES(N), .PULSE_LEN(PL)) dut_i (
        .clk            (clk),
        .rst            (rst),
        .frame_step     (step),
        .mux_mode       (mode),
        .sync_line_in   (line),
        .bp_index       (bp_index),
        .sync_pull_down (pull)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_pend = 0; m_drv = 0; m_left = 0;
            line_h = {};
            drv_h  = {};
            for (int i = 0; i <= N; i++) begin
                line_h.push_back(1'b1);
                drv_h.push_back(1'b0);
            end
        end else begin
            bit mline, fall, re, start;
            int last;
            mline = ~(m_drv | foreign);
            fall  = line_h[N] && !line_h[N-1] && !drv_h[N-1];
            re    = m_pend || fall;
            last  = mode;
            start = 0;
            if (step) begin
                if (re) m_ph = last;
                else begin
                    m_ph  = (m_ph >= last) ? 0 : m_ph + 1;
                    start = (m_ph == last);
                end
                m_pend = 0;
            end else if (fall) m_pend = 1;
            line_h.push_front(mline); void'(line_h.pop_back());
            drv_h.push_front(m_drv);  void'(drv_h.pop_back());
            if (start) begin
                m_drv = 1; m_left = PL - 1;
            end else if (m_drv) begin
                if (m_left == 0) m_drv = 0;
                else m_left--;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && cmp_en) begin
            chk({cur_req, " bp_index"}, bp_index, m_ph);
            chk({cur_req, " sync_pull_down"}, pull, m_drv);
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_step(int gap);
        @(negedge clk) step = 1'b1;
        @(negedge clk) step = 1'b0;
        idle(gap);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; step = 1'b0; mode = 2'b11; foreign = 1'b0;
        idle(4);
        chk("R1 bp_index in reset", bp_index, 0);
        chk("R1 pull in reset", pull, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 bp_index after reset", bp_index, 0);
        chk("R1 pull after reset", pull, 0);
        cmp_en = 1;

        // free run, 1:4, own pulses only
        cur_req = "R2/R4/R6";
        for (int k = 0; k < 12; k++) do_step(5);

        // hold without step
        begin
            int held;
            held = bp_index;
            idle(6);
            chk("R3 hold", bp_index, held);
        end

        // other modes
        for (int md = 0; md < 3; md++) begin
            mode = 2'(md);
            for (int k = 0; k < 9; k++) do_step(5);
        end
        mode = 2'b00;
        do_step(0);
        chk("R2 static index", bp_index, 0);
        chk("R4 static pulse", pull, 1);
        idle(5);

        // foreign edge mid-frame
        mode = 2'b11;
        cur_req = "R5/R9";
        while (m_ph != 1) do_step(5);
        @(negedge clk) foreign = 1'b1;
        idle(2);
        foreign = 1'b0;
        idle(4);
        do_step(0);
        chk("R5 realign to last", bp_index, 3);
        idle(1);
        chk("R5 no pulse on realign", pull, 0);
        idle(4);
        do_step(0);
        chk("R9 wrap after realign", bp_index, 0);
        idle(5);
        do_step(0);
        chk("R9 normal advance", bp_index, 1);
        idle(5);

        // late foreign edge, step one edge too early
        cur_req = "R7";
        while (m_ph != 0) do_step(5);
        @(negedge clk) foreign = 1'b1;
        @(negedge clk) step = 1'b1;
        @(negedge clk) begin step = 1'b0; foreign = 1'b0; end
        chk("R7 early step not realigned", bp_index, 1);
        idle(5);
        do_step(0);
        chk("R7 pending realign applied", bp_index, 3);
        idle(5);

        // mode shrink
        cur_req = "R8";
        while (m_ph != 3) do_step(5);
        idle(3);
        mode = 2'b01;
        do_step(0);
        chk("R8 wrap after mode shrink", bp_index, 0);
        idle(5);
        do_step(0);
        chk("R8 advance in new mode", bp_index, 1);
        idle(5);
        for (int k = 0; k < 4; k++) do_step(5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule